// File: doc/BRIEF.md
# Capture buffer serial dump controller

This block empties a frozen sample buffer over a byte-serial line once a capture has finished. When the capture core raises its done flag, the controller begins at the oldest stored entry, which the core names through a start pointer. It walks the whole ring in time order and cuts each wide sample into bytes. Each byte is sent through an internal 8N1 transmitter at a fixed bit rate.

The buffer is read through a synchronous port that returns data one cycle after the address is presented. The controller therefore holds each address for a full cycle before it latches the word. After the stop bit of the final byte has left the line, a one-cycle re-arm pulse goes back to the capture core so that it can start a fresh acquisition. A busy flag covers the whole dump.

Top module: `capture_dump_ctrl`

## Requirements
- R1: After reset the serial line is high (idle), busy is low and re-arm is low.
- R2: While the done flag is low in the idle state, nothing is transmitted: the line stays high and busy stays low.
- R3: The cycle after the done flag is seen in the idle state, busy goes high. It stays high through the re-arm cycle and is low in the cycle after it.
- R4: Exactly DEPTH samples are sent per dump, oldest first. The first address is the start pointer, and the address wraps from DEPTH-1 to 0. Each word is taken one cycle after its address was presented.
- R5: Each sample goes out as SAMPLE_W/8 bytes, least significant byte first.
- R6: Each byte is framed as one start bit (0), eight data bits sent LSB first, and one stop bit (1), with no parity. Every bit lasts CLK_HZ/BAUD clock cycles.
- R7: A byte is loaded only when the transmitter is idle, so no frame is cut short or overlapped and no byte is lost.
- R8: Re-arm is a single-cycle pulse. It is issued only after the stop bit of the last byte has completed, and the line is high while it is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_done_i | input | 1 | Capture finished; starts a dump |
| start_ptr_i | input | $clog2(DEPTH) | Address of the oldest stored sample |
| rd_addr_o | output | $clog2(DEPTH) | Buffer read address |
| rd_data_i | input | SAMPLE_W | Buffer read data, one cycle after the address |
| txd_o | output | 1 | Serial transmit line |
| busy_o | output | 1 | Dump in progress |
| rearm_o | output | 1 | One-cycle pulse to restart the capture core |

## Verification
Busy is due at the first falling clock edge after the edge that sees the done flag. The bench drives done at a falling edge and samples busy exactly one half-cycle after the next rising edge. Serial data only settles one divider period per bit. The receiver model therefore finds the start bit at a falling edge, moves half a bit period into it, and then samples every full period, so each bit is read near its centre. Re-arm is due about half a bit after the last stop bit is sampled. The bench checks at the re-arm cycle that every byte has already arrived, and checks one cycle later that busy has dropped.

// File: rtl/capture_dump_ctrl.sv
module capture_dump_ctrl #(
  parameter int SAMPLE_W = 128,
  parameter int DEPTH    = 512,
  parameter int CLK_HZ   = 100_000_000,
  parameter int BAUD     = 500_000,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int BYTES   = SAMPLE_W / 8,
  localparam int BIDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1,
  localparam int DIV     = CLK_HZ / BAUD,
  localparam int DIV_W   = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_done_i,
  input  logic [ADDR_W-1:0]   start_ptr_i,
  output logic [ADDR_W-1:0]   rd_addr_o,
  input  logic [SAMPLE_W-1:0] rd_data_i,
  output logic                txd_o,
  output logic                busy_o,
  output logic                rearm_o
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_SEND, S_NEXT, S_REARM} state_t;

  state_t                state;
  logic [ADDR_W-1:0]     rd_addr, sent;
  logic [BIDX_W-1:0]     byte_idx;
  logic                  fetch_wait;
  logic [SAMPLE_W-1:0]   word;
  logic                  tx_busy;
  logic [DIV_W-1:0]      tx_div;
  logic [3:0]            tx_bit;
  logic [9:0]            tx_frame;
  logic                  tx_load;

  assign tx_load   = (state == S_SEND) && !tx_busy;
  assign rd_addr_o = rd_addr;
  assign txd_o     = tx_busy ? tx_frame[0] : 1'b1;
  assign busy_o    = (state != S_IDLE);
  assign rearm_o   = (state == S_REARM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      rd_addr    <= '0;
      sent       <= '0;
      byte_idx   <= '0;
      fetch_wait <= 1'b0;
      word       <= '0;
    end else begin
      case (state)
        S_IDLE: if (cap_done_i) begin
          rd_addr    <= start_ptr_i;
          sent       <= '0;
          fetch_wait <= 1'b1;
          state      <= S_FETCH;
        end
        S_FETCH: if (fetch_wait) fetch_wait <= 1'b0;
        else begin
          word     <= rd_data_i;
          byte_idx <= '0;
          state    <= S_SEND;
        end
        S_SEND: if (!tx_busy) begin
          word     <= word >> 8;
          byte_idx <= byte_idx + 1'b1;
          if (byte_idx == BIDX_W'(BYTES - 1)) state <= S_NEXT;
        end
        S_NEXT: if (sent == ADDR_W'(DEPTH - 1)) begin
          if (!tx_busy) state <= S_REARM;
        end else begin
          sent       <= sent + 1'b1;
          rd_addr    <= (rd_addr == ADDR_W'(DEPTH - 1)) ? '0 : rd_addr + 1'b1;
          fetch_wait <= 1'b1;
          state      <= S_FETCH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy  <= 1'b0;
      tx_div   <= '0;
      tx_bit   <= '0;
      tx_frame <= '1;
    end else if (tx_load) begin
      tx_busy  <= 1'b1;
      tx_div   <= '0;
      tx_bit   <= '0;
      tx_frame <= {1'b1, word[7:0], 1'b0};
    end else if (tx_busy) begin
      if (tx_div == DIV_W'(DIV - 1)) begin
        tx_div   <= '0;
        tx_frame <= {1'b1, tx_frame[9:1]};
        if (tx_bit == 4'd9) tx_busy <= 1'b0;
        else tx_bit <= tx_bit + 1'b1;
      end else begin
        tx_div <= tx_div + 1'b1;
      end
    end
  end

  // R2
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> txd_o);

  // R3
  done_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && cap_done_i) |=> busy_o);

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SEND) |=> $stable(rd_addr_o));

  // R6
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bit <= 4'd9);

  // R7
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |=> !txd_o);

  // R8
  rearm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_o |=> !rearm_o && !busy_o);

  // R8
  rearm_line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_o |-> txd_o && !tx_busy);

endmodule

// File: tb/capture_dump_ctrl_tb_top.sv
module capture_dump_ctrl_tb_top;
  localparam int SW = 32, DP = 8, HZ = 4_000_000, BR = 500_000;
  localparam int DIV = HZ / BR, NB = SW / 8, AW = $clog2(DP);

  logic clk = 1'b0, rst_n = 1'b0, done = 1'b0;
  logic [AW-1:0] sptr = '0, raddr;
  logic [SW-1:0] rdata, mem [0:DP-1];
  logic txd, busy, rearm;
  int tests = 0, fails = 0;
  logic [7:0] rx_buf [0:63];
  int rx_n = 0;

  always #2.5 clk = ~clk;

  capture_dump_ctrl #(.SAMPLE_W(SW), .DEPTH(DP), .CLK_HZ(HZ), .BAUD(BR)) dut_i (
    .clk(clk), .rst_n(rst_n), .cap_done_i(done), .start_ptr_i(sptr),
    .rd_addr_o(raddr), .rd_data_i(rdata), .txd_o(txd), .busy_o(busy), .rearm_o(rearm));

  always @(posedge clk) rdata <= mem[raddr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        logic [7:0] b;
        repeat (DIV / 2) @(negedge clk);
        chk(txd === 1'b0, "R6 start bit", int'(txd), 0);
        for (int i = 0; i < 8; i++) begin
          repeat (DIV) @(negedge clk);
          b[i] = txd;
        end
        repeat (DIV) @(negedge clk);
        chk(txd === 1'b1, "R6 stop bit", int'(txd), 1);
        if (rx_n < 64) rx_buf[rx_n] = b;
        rx_n++;
      end
    end
  end

  task automatic dump(input int seed, input logic [AW-1:0] sp, input bit pulse);
    int lowb = 0, n = 0;
    for (int a = 0; a < DP; a++) mem[a] = SW'(a * 32'h0103_0507 + seed * 32'h1F00_0011);
    rx_n = 0;
    sptr = sp;
    @(negedge clk) done = 1'b1;
    @(negedge clk);
    if (pulse) done = 1'b0;
    // R3: busy due one cycle after done seen
    chk(busy === 1'b1, "R3 busy rise", int'(busy), 1);
    while (rearm !== 1'b1 && n < 20000) begin
      @(negedge clk);
      n++;
      if (busy !== 1'b1) lowb++;
    end
    chk(lowb == 0, "R3 busy held", lowb, 0);
    // R8: every byte done before re-arm, line idle
    chk(rx_n == DP * NB, "R8 bytes before rearm", rx_n, DP * NB);
    chk(txd === 1'b1, "R8 line high at rearm", int'(txd), 1);
    done = 1'b0;
    @(negedge clk);
    chk(rearm === 1'b0, "R8 single pulse", int'(rearm), 0);
    chk(busy === 1'b0, "R3 busy falls", int'(busy), 0);
    // R4 R5 R7: order, byte order, no lost bytes
    for (int k = 0; k < DP; k++)
      for (int j = 0; j < NB; j++) begin
        logic [SW-1:0] w;
        logic [7:0] e;
        w = mem[(int'(sp) + k) % DP];
        e = w[8*j +: 8];
        chk(rx_buf[k * NB + j] == e, "R4 R5 R7 byte", int'(rx_buf[k * NB + j]), int'(e));
      end
  endtask

  task automatic quiet(input int cycles);
    int bad = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (txd !== 1'b1 || busy !== 1'b0 || rearm !== 1'b0) bad++;
    end
    chk(bad == 0 && rx_n_snapshot_ok(), "R2 idle quiet", bad, 0);
  endtask

  function automatic bit rx_n_snapshot_ok();
    return 1'b1;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1, "R1 txd", int'(txd), 1);
    chk(busy === 1'b0, "R1 busy", int'(busy), 0);
    chk(rearm === 1'b0, "R1 rearm", int'(rearm), 0);
    quiet(150);
    dump(1, AW'(0), 1'b0);
    quiet(100);
    dump(7, AW'(5), 1'b1);
    quiet(100);
    dump(3, AW'(DP - 1), 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule